// File: doc/BRIEF.md
# Budgeted Priority Transaction Queue

This block keeps a pool of pending single transactions waiting for an asynchronous bus slot. Each transaction arrives with a 3-bit priority, a 16-bit execution-time estimate in microseconds and an 8-bit tag. On arrival it is stamped from a free-running 16-bit counter. The pool is held as a binary min-heap. Its key is the priority (0 is most urgent) followed by the arrival stamp, so entries with equal priority keep their arrival order.

When the scheduler strobes `prepare`, the block samples `budget` and walks the heap in key order. Every entry whose estimate fits the budget still remaining is selected, and that estimate is subtracted from the remainder. An entry that is too large is parked so that smaller entries behind it can still be taken. After the walk, the parked entries are pushed back into the heap with their original stamps. The selected tags then stream out on a valid/ready port, and the final tag carries a last marker. `prep_done` pulses when the whole list has been delivered. No insert is accepted from the prepare strobe until that pulse.

Top module: `pq_budget_queue`

## Requirements
- R1: Selected tags leave in ascending key order. Priority 0 comes first, and within one priority the earlier-inserted entry comes first.
- R2: An entry is selected when its estimate is less than or equal to the budget remaining at that point; an exact fill counts. The estimates of the selected entries never sum to more than the sampled budget.
- R3: An entry that does not fit is passed over, and later entries in key order that do fit are still selected.
- R4: Passed-over entries stay in the queue with their original stamps. A later prepare returns them in their original relative order.
- R5: The queue holds 16 entries. An insert handshake made while 16 entries are held does not store the entry, and `in_overflow` is high for exactly the cycle after that handshake.
- R6: A prepare that selects nothing, either because the queue is empty or because nothing fits, pulses `prep_done` without ever raising `out_valid`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_tag` and `out_last` hold their values.
- R8: `out_last` is high only on the final tag of a list. `prep_done` pulses in the cycle after that tag's handshake.
- R9: `in_ready` is low from the `prepare` strobe until `prep_done`, and in particular whenever `out_valid` is high.
- R10: After reset `in_ready` is high, `out_valid` and `prep_done` are low, and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Insert request |
| in_ready | output | 1 | Insert accepted this cycle when high with in_valid |
| in_prio | input | 3 | Priority, 0 most urgent |
| in_est | input | 16 | Execution-time estimate (µs) |
| in_tag | input | 8 | Transaction tag |
| in_overflow | output | 1 | Pulse: last accepted insert was dropped, queue full |
| prepare | input | 1 | Strobe starting a slot extraction |
| budget | input | 16 | Slot budget (µs), sampled with prepare |
| out_valid | output | 1 | Extracted tag available |
| out_ready | input | 1 | Consumer takes the tag |
| out_tag | output | 8 | Extracted tag |
| out_last | output | 1 | Final tag of this slot's list |
| prep_done | output | 1 | Pulse: extraction and delivery complete |

## Verification
`in_overflow` is due one cycle after the insert handshake edge. The bench drives inputs on falling edges and samples that flag on the next falling edge. The length of an extraction depends on heap sift depth, so the bench does not predict its cycle count. It polls every falling edge after the strobe, records each tag whose handshake will occur at the coming rising edge, and treats the first `prep_done` as the end of the list. The interval between the last handshake and `prep_done`, and tag stability under backpressure, are held to a single cycle by the checker properties.

// File: rtl/pq_pkg.sv
package pq_pkg;
    localparam int PRIO_W  = 3;
    localparam int EST_W   = 16;
    localparam int TAG_W   = 8;
    localparam int STAMP_W = 16;

    typedef struct packed {
        logic [PRIO_W-1:0]  prio;
        logic [STAMP_W-1:0] stamp;
        logic [EST_W-1:0]   est;
        logic [TAG_W-1:0]   tag;
    } pq_entry_t;

    typedef enum logic [1:0] {H_IDLE, H_UP, H_DOWN} heap_st_e;
    typedef enum logic [1:0] {C_IDLE, C_SCAN, C_REINS, C_EMIT} ctl_st_e;

    // Ordering key: priority first, then arrival stamp.
    function automatic logic key_less(pq_entry_t a, pq_entry_t b);
        return {a.prio, a.stamp} < {b.prio, b.stamp};
    endfunction
endpackage

// File: rtl/pq_stamp.sv
module pq_stamp
    import pq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [STAMP_W-1:0] stamp
);
    always_ff @(posedge clk) begin
        if (rst) stamp <= '0;
        else     stamp <= stamp + 1'b1;
    end
endmodule

// File: rtl/pq_list.sv
module pq_list #(
    parameter int  DEPTH = 16,
    parameter type T     = logic [7:0],
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          wr,
    input  T              wr_e,
    input  logic [CW-1:0] rd_idx,
    output T              rd_e,
    output logic [CW-1:0] count
);
    T mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (wr) begin
            mem[count[IW-1:0]] <= wr_e;
            count <= count + 1'b1;
        end
    end

    assign rd_e = mem[rd_idx[IW-1:0]];
endmodule

// File: rtl/pq_heap.sv
module pq_heap
    import pq_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int IW    = $clog2(DEPTH),
    localparam int CW    = IW + 1,
    localparam int XW    = IW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  pq_entry_t     push_e,
    input  logic          pop,
    output pq_entry_t     top_e,
    output logic [CW-1:0] count,
    output logic          busy
);
    pq_entry_t     mem [DEPTH];
    heap_st_e      st;
    logic [IW-1:0] idx, parent, last_i, sm_i;
    logic [XW-1:0] lc, rc, sm, cnt_x;

    always_comb begin
        parent = (idx - 1'b1) >> 1;
        last_i = IW'(count - 1'b1);
        cnt_x  = {1'b0, count};
        lc     = {1'b0, idx, 1'b1};
        rc     = lc + 1'b1;
        sm     = {2'b00, idx};
        if (lc < cnt_x && key_less(mem[lc[IW-1:0]], mem[idx]))      sm = lc;
        if (rc < cnt_x && key_less(mem[rc[IW-1:0]], mem[sm[IW-1:0]])) sm = rc;
        sm_i   = sm[IW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= H_IDLE;
            count <= '0;
            idx   <= '0;
        end else begin
            case (st)
                H_IDLE: begin
                    if (push) begin
                        mem[count[IW-1:0]] <= push_e;
                        idx   <= count[IW-1:0];
                        count <= count + 1'b1;
                        st    <= H_UP;
                    end else if (pop) begin
                        mem[0] <= mem[last_i];
                        count  <= count - 1'b1;
                        idx    <= '0;
                        st     <= (count > CW'(2)) ? H_DOWN : H_IDLE;
                    end
                end
                H_UP: begin
                    if (idx != '0 && key_less(mem[idx], mem[parent])) begin
                        mem[idx]    <= mem[parent];
                        mem[parent] <= mem[idx];
                        idx         <= parent;
                    end else begin
                        st <= H_IDLE;
                    end
                end
                H_DOWN: begin
                    if (sm != {2'b00, idx}) begin
                        mem[idx]  <= mem[sm_i];
                        mem[sm_i] <= mem[idx];
                        idx       <= sm_i;
                    end else begin
                        st <= H_IDLE;
                    end
                end
                default: st <= H_IDLE;
            endcase
        end
    end

    assign top_e = mem[0];
    assign busy  = (st != H_IDLE);
endmodule

// File: rtl/pq_budget_queue.sv
module pq_budget_queue
    import pq_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PRIO_W-1:0] in_prio,
    input  logic [EST_W-1:0]  in_est,
    input  logic [TAG_W-1:0]  in_tag,
    output logic              in_overflow,
    input  logic              prepare,
    input  logic [EST_W-1:0]  budget,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_last,
    output logic              prep_done
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    ctl_st_e            st;
    logic               prep_pend, start, fits;
    logic [EST_W-1:0]   bud_q, rem;
    logic [CW-1:0]      ridx, eidx;
    logic [STAMP_W-1:0] stamp;

    logic               h_push, h_pop, h_busy;
    pq_entry_t          h_push_e, h_top;
    logic [CW-1:0]      h_cnt;
    logic               s_wr, a_wr;
    logic [TAG_W-1:0]   s_rd;
    pq_entry_t          a_rd;
    logic [CW-1:0]      s_cnt, a_cnt;

    pq_stamp u_stamp (.clk(clk), .rst(rst), .stamp(stamp));

    pq_heap #(.DEPTH(DEPTH)) u_heap (
        .clk(clk), .rst(rst), .push(h_push), .push_e(h_push_e), .pop(h_pop),
        .top_e(h_top), .count(h_cnt), .busy(h_busy)
    );

    pq_list #(.DEPTH(DEPTH), .T(logic [TAG_W-1:0])) u_sel (
        .clk(clk), .rst(rst), .clear(start), .wr(s_wr), .wr_e(h_top.tag),
        .rd_idx(eidx), .rd_e(s_rd), .count(s_cnt)
    );

    pq_list #(.DEPTH(DEPTH), .T(pq_entry_t)) u_aside (
        .clk(clk), .rst(rst), .clear(start), .wr(a_wr), .wr_e(h_top),
        .rd_idx(ridx), .rd_e(a_rd), .count(a_cnt)
    );

    assign in_ready  = (st == C_IDLE) && !h_busy && !prep_pend && !prepare;
    assign start     = (st == C_IDLE) && !h_busy && prep_pend;
    assign fits      = (h_top.est <= rem);
    assign out_valid = (st == C_EMIT);
    assign out_tag   = s_rd;
    assign out_last  = out_valid && (eidx == s_cnt - 1'b1);

    always_comb begin
        h_push   = 1'b0;
        h_push_e = '0;
        h_pop    = 1'b0;
        s_wr     = 1'b0;
        a_wr     = 1'b0;
        case (st)
            C_IDLE: if (in_valid && in_ready && h_cnt != FULL) begin
                h_push   = 1'b1;
                h_push_e = '{prio: in_prio, stamp: stamp, est: in_est, tag: in_tag};
            end
            C_SCAN: if (!h_busy && h_cnt != '0) begin
                h_pop = 1'b1;
                s_wr  = fits;
                a_wr  = !fits;
            end
            C_REINS: if (!h_busy && ridx < a_cnt) begin
                h_push   = 1'b1;
                h_push_e = a_rd;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= C_IDLE;
            prep_pend   <= 1'b0;
            bud_q       <= '0;
            rem         <= '0;
            ridx        <= '0;
            eidx        <= '0;
            in_overflow <= 1'b0;
            prep_done   <= 1'b0;
        end else begin
            in_overflow <= 1'b0;
            prep_done   <= 1'b0;
            prep_pend   <= prepare | (prep_pend & !start);
            if (prepare) bud_q <= budget;
            case (st)
                C_IDLE: begin
                    if (in_valid && in_ready && h_cnt == FULL) in_overflow <= 1'b1;
                    if (start) begin
                        st   <= C_SCAN;
                        rem  <= bud_q;
                        ridx <= '0;
                        eidx <= '0;
                    end
                end
                C_SCAN: if (!h_busy) begin
                    if (h_cnt == '0)  st  <= C_REINS;
                    else if (fits)    rem <= rem - h_top.est;
                end
                C_REINS: if (!h_busy) begin
                    if (ridx < a_cnt) begin
                        ridx <= ridx + 1'b1;
                    end else if (s_cnt == '0) begin
                        prep_done <= 1'b1;
                        st        <= C_IDLE;
                    end else begin
                        st <= C_EMIT;
                    end
                end
                C_EMIT: if (out_ready) begin
                    if (out_last) begin
                        prep_done <= 1'b1;
                        st        <= C_IDLE;
                    end else begin
                        eidx <= eidx + 1'b1;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pq_budget_queue_chk.sv
module pq_budget_queue_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_overflow,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_tag,
    input logic       out_last,
    input logic       prep_done
);
    // R9
    stall_during_emit_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

    // R7
    hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_last));

    // R5
    overflow_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        in_overflow |-> $past(in_valid && in_ready));

    // R8
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready && out_last |=> prep_done);

    // R8
    last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        prep_done |-> !out_valid);
endmodule

bind pq_budget_queue pq_budget_queue_chk chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_overflow(in_overflow), .out_valid(out_valid), .out_ready(out_ready),
    .out_tag(out_tag), .out_last(out_last), .prep_done(prep_done)
);

// File: tb/pq_budget_queue_tb_top.sv
module pq_budget_queue_tb_top;
    localparam int CLK_P = 10;
    localparam int QMAX  = 16;
    localparam int WDOG  = 150000;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, prepare = 1'b0, out_ready = 1'b0;
    logic [2:0] in_prio = '0;
    logic [15:0] in_est = '0, budget = '0;
    logic [7:0] in_tag = '0;
    logic in_ready, in_overflow, out_valid, out_last, prep_done;
    logic [7:0] out_tag;

    int tests = 0, fails = 0, cycles = 0;
    int mp[QMAX], me[QMAX], mt[QMAX], ms[QMAX];
    int mn = 0, seqc = 0;
    int exp_t[QMAX], exp_n;
    int got_t[64], got_l[64], got_n;
    int est_of[256];
    int tagc = 0;

    pq_budget_queue dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_prio(in_prio), .in_est(in_est), .in_tag(in_tag), .in_overflow(in_overflow),
        .prepare(prepare), .budget(budget), .out_valid(out_valid), .out_ready(out_ready),
        .out_tag(out_tag), .out_last(out_last), .prep_done(prep_done)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG) begin
            fails++;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, WDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, expv);
        end
    endtask

    // Reference selection: key order (priority, insertion sequence), take what fits.
    task automatic model_prepare(input int b);
        bit used[QMAX];
        bit take[QMAX];
        int rem = b;
        int k;
        exp_n = 0;
        for (int i = 0; i < QMAX; i++) begin used[i] = 0; take[i] = 0; end
        for (int n = 0; n < mn; n++) begin
            int best = -1;
            for (int i = 0; i < mn; i++)
                if (!used[i] && (best < 0 || mp[i] < mp[best] ||
                                 (mp[i] == mp[best] && ms[i] < ms[best]))) best = i;
            used[best] = 1;
            if (me[best] <= rem) begin
                rem -= me[best];
                take[best] = 1;
                exp_t[exp_n++] = mt[best];
            end
        end
        k = 0;
        for (int i = 0; i < mn; i++) if (!take[i]) begin
            mp[k] = mp[i]; me[k] = me[i]; mt[k] = mt[i]; ms[k] = ms[i]; k++;
        end
        mn = k;
    endtask

    task automatic ins(input int p, input int e, input int t);
        bit full = (mn == QMAX);
        @(negedge clk);
        in_valid = 1'b1; in_prio = 3'(p); in_est = 16'(e); in_tag = 8'(t);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_overflow == full, "R5 overflow flag", int'(in_overflow), int'(full));
        if (!full) begin
            mp[mn] = p; me[mn] = e; mt[mn] = t; ms[mn] = seqc++; mn++;
            est_of[t] = e;
        end
    endtask

    task automatic run_prep(input int b, input bit bp);
        int cyc = 0, sum = 0;
        bit done = 0;
        model_prepare(b);
        @(negedge clk);
        prepare = 1'b1; budget = 16'(b);
        @(negedge clk);
        prepare = 1'b0;
        got_n = 0;
        while (!done && cyc < 4000) begin
            if (prep_done) begin
                done = 1;
            end else begin
                out_ready = bp ? ($urandom % 3 != 0) : 1'b1;
                if (out_valid && in_ready) chk(0, "R9 in_ready during output", 1, 0);
                if (out_valid && out_ready && got_n < 64) begin
                    got_t[got_n] = out_tag; got_l[got_n] = out_last; got_n++;
                end
                @(negedge clk);
                cyc++;
            end
        end
        out_ready = 1'b0;
        chk(done, "R8 prep_done seen", int'(done), 1);
        chk(got_n == exp_n, "R6 selected count", got_n, exp_n);
        for (int i = 0; i < got_n && i < exp_n; i++) begin
            chk(got_t[i] == exp_t[i], "R1 R3 R4 tag order", got_t[i], exp_t[i]);
            chk(got_l[i] == (i == got_n - 1), "R8 last marker", got_l[i], int'(i == got_n - 1));
            sum += est_of[got_t[i]];
        end
        chk(sum <= b, "R2 budget respected", sum, b);
        chk(in_ready == 1'b1, "R9 in_ready after done", int'(in_ready), 1);
    endtask

    task automatic new_ins(input int p, input int e);
        ins(p, e, tagc);
        tagc = (tagc + 1) % 256;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        chk(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
        chk(prep_done == 1'b0, "R10 prep_done", int'(prep_done), 0);
        // R6 / R10: empty queue
        run_prep(1000, 0);

        // R1: ties keep arrival order
        tagc = 10;
        new_ins(2, 10); new_ins(2, 10); new_ins(2, 10); new_ins(1, 10);
        run_prep(1000, 1);

        // R2 exact fill, R3 skip, R6 nothing fits, R4 reinsertion order
        ins(0, 300, 20); ins(1, 150, 21); ins(4, 50, 22); ins(6, 100, 23);
        run_prep(200, 1);
        run_prep(0, 0);
        run_prep(1000, 1);

        // R5: fill past capacity
        tagc = 40;
        for (int i = 0; i < QMAX + 2; i++) new_ins(i % 8, 5);
        run_prep(65535, 1);

        // Random mix
        tagc = 100;
        for (int r = 0; r < 60; r++) begin
            int k = (r % 15 == 14) ? 20 : int'($urandom % 8);
            for (int j = 0; j < k; j++) new_ins(int'($urandom % 8), int'($urandom % 400) + 1);
            run_prep(int'($urandom % 1200), 1);
        end
        run_prep(65535, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule